// File: doc/BRIEF.md
# Offset-Coded Clock Divider Bank

This block holds the three integer dividers that sit around a frequency-synthesis loop. A reference divider slows the incoming reference clock. A feedback divider slows the oscillator-rate clock for comparison against that reference. A post scaler produces the delivered output clock from the oscillator-rate clock. None of the three ratios is the raw code. The reference ratio is its 6-bit code plus two. The feedback ratio is its 8-bit code plus eight. The post-scaler ratio is two raised to its 2-bit code. The delivered frequency is therefore F_ref x (M+8) / ((P+2) x 2^S).

All three codes arrive together in a single 16-bit word. A test select input can replace the whole word with a second word taken from test pins. Each divider keeps a shadow copy of its ratio and takes a new value only when it wraps from its last count back to zero. A code change therefore never cuts a divided-clock pulse short. Odd ratios use a half-cycle helper register on the falling edge, so the high phase is exactly half the period. A synchronous power-down input holds every divider quiet and its output low.

Top module: `synth_div_bank`

## Requirements
- R1: `ref_div_o` has a period of (P+2) cycles of `clk_ref`, where P is bits [7:2] of the selected word, across the full code range 0 to 63.
- R2: `fb_div_o` has a period of (M+8) cycles of `clk_vco`, where M is bits [15:8] of the selected word, across the full code range 0 to 255.
- R3: `out_clk_o` has a period of 2^S cycles of `clk_vco`, where S is bits [1:0] of the selected word (ratios 1, 2, 4, 8).
- R4: The word splits into the feedback code in [15:8], the reference code in [7:2] and the scaler code in [1:0], and all three decode at the same time.
- R5: For an odd ratio N, the output is high for N/2 input cycles (a whole number of cycles plus one half), starting at a rising edge.
- R6: For an even ratio N, the output is high for exactly N/2 input cycles.
- R7: A new code changes a divider only at the end of its current period, so a period that is running when the code changes completes at the old length.
- R8: While `pwr_dn` is high, all three outputs go low within one cycle of their own clock and stay low. After release, they restart at the programmed ratios.
- R9: With `tst_sel` high, `tst_word` replaces `cfg_word` for all three dividers. With `tst_sel` low, `cfg_word` is used.
- R10: `rst` is active high and synchronous. While it is held, all outputs are low and every counter is cleared.
- R11: With scaler code 0, `out_clk_o` follows `clk_vco`: high for the first half of each cycle and low for the second half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| clk_vco | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Power-down, active high, silences all outputs |
| cfg_word | input | 16 | Normal configuration word: feedback, reference and scaler codes |
| tst_sel | input | 1 | Selects `tst_word` instead of `cfg_word` |
| tst_word | input | 16 | Test-pin configuration word, same layout |
| ref_div_o | output | 1 | Divided reference clock |
| fb_div_o | output | 1 | Divided feedback clock |
| out_clk_o | output | 1 | Post-scaled output clock |

## Verification
A corrupted shadow ratio or counter shows up at the output pin within one divided period, as a rising-edge spacing or a high time that differs from the expected value. For this reason every check measures whole periods and high phases in picoseconds against values derived from the codes. A shadow that loads too early is visible on the first period after a code change made partway through a period. That period must still have the old length. A fault in the falling-edge helper register shows at once as a high phase that is half a cycle off on odd ratios, or as a dead output at ratio 1.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int FB_CODE_W   = 8;
  localparam int PRE_CODE_W  = 6;
  localparam int POST_CODE_W = 2;
  localparam int FB_OFFSET   = 8;
  localparam int PRE_OFFSET  = 2;

  // bits needed to hold the largest ratio a code of width w plus offset can give
  function automatic int ratio_bits(input int w, input int ofs);
    return $clog2((1 << w) + ofs);
  endfunction
endpackage

// File: rtl/sdiv_word_sel.sv
module sdiv_word_sel #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] tst_word,
  input  logic              tst_sel,
  output logic [WORD_W-1:0] word_o
);
  // one select line steers every configuration bit
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign word_o[b] = tst_sel ? tst_word[b] : cfg_word[b];
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd,
  input  logic [RW-1:0] ratio_in,
  output logic          div_o
);
  logic [RW-1:0] sh_q, cnt_q, nxt_ratio, nxt_cnt;
  logic          term;
  logic          hi_p, hi_n, odd_q, one_q, tog_p, tog_n;

  assign term      = (cnt_q == sh_q - 1'b1);
  assign nxt_ratio = term ? ratio_in : sh_q;
  assign nxt_cnt   = term ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      sh_q  <= ratio_in;
      cnt_q <= ratio_in - 1'b1;   // next edge wraps and starts a full period
      hi_p  <= 1'b0;
      odd_q <= 1'b0;
      one_q <= 1'b0;
      tog_p <= 1'b0;
    end else begin
      sh_q  <= nxt_ratio;
      cnt_q <= nxt_cnt;
      hi_p  <= (nxt_cnt < (nxt_ratio >> 1));
      odd_q <= nxt_ratio[0];
      one_q <= (nxt_ratio == RW'(1));
      tog_p <= (nxt_ratio == RW'(1)) ? ~tog_p : 1'b0;
    end
  end

  // falling-edge helpers: half-cycle extension for odd ratios, pass-through for ratio 1
  always_ff @(negedge clk) begin
    if (rst || pd) begin
      hi_n  <= 1'b0;
      tog_n <= 1'b0;
    end else begin
      hi_n  <= hi_p;
      tog_n <= tog_p;
    end
  end

  assign div_o = one_q ? (tog_p ^ tog_n) : (hi_p | (odd_q & hi_n));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < sh_q); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst || pd)
    !$past(term) |-> $stable(sh_q)); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst || pd)
    term |=> (cnt_q == '0)); // R1
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pd && $past(pd)) |-> !div_o); // R8
endmodule

// File: rtl/synth_div_bank.sv
module synth_div_bank
  import sdiv_pkg::*;
#(
  parameter int FB_W    = FB_CODE_W,
  parameter int PRE_W   = PRE_CODE_W,
  parameter int POST_W  = POST_CODE_W,
  parameter int FB_OFS  = FB_OFFSET,
  parameter int PRE_OFS = PRE_OFFSET
) (
  input  logic                          clk_ref,
  input  logic                          clk_vco,
  input  logic                          rst,
  input  logic                          pwr_dn,
  input  logic [FB_W+PRE_W+POST_W-1:0]  cfg_word,
  input  logic                          tst_sel,
  input  logic [FB_W+PRE_W+POST_W-1:0]  tst_word,
  output logic                          ref_div_o,
  output logic                          fb_div_o,
  output logic                          out_clk_o
);
  localparam int WORD_W  = FB_W + PRE_W + POST_W;
  localparam int FB_RW   = ratio_bits(FB_W, FB_OFS);
  localparam int PRE_RW  = ratio_bits(PRE_W, PRE_OFS);
  localparam int POST_RW = 1 << POST_W;

  logic [WORD_W-1:0]  word;
  logic [FB_W-1:0]    fb_code;
  logic [PRE_W-1:0]   pre_code;
  logic [POST_W-1:0]  post_code;
  logic [FB_RW-1:0]   fb_ratio;
  logic [PRE_RW-1:0]  pre_ratio;
  logic [POST_RW-1:0] post_ratio;

  sdiv_word_sel #(.WORD_W(WORD_W)) u_sel (
    .cfg_word (cfg_word),
    .tst_word (tst_word),
    .tst_sel  (tst_sel),
    .word_o   (word)
  );

  // layout: feedback code on top, reference code in the middle, scaler code at the bottom
  assign fb_code   = word[WORD_W-1 -: FB_W];
  assign pre_code  = word[POST_W +: PRE_W];
  assign post_code = word[POST_W-1:0];

  assign fb_ratio   = FB_RW'(fb_code) + FB_RW'(FB_OFS);
  assign pre_ratio  = PRE_RW'(pre_code) + PRE_RW'(PRE_OFS);
  assign post_ratio = POST_RW'(1) << post_code;

  sdiv_core #(.RW(PRE_RW)) u_pre (
    .clk (clk_ref), .rst (rst), .pd (pwr_dn),
    .ratio_in (pre_ratio), .div_o (ref_div_o)
  );

  sdiv_core #(.RW(FB_RW)) u_fb (
    .clk (clk_vco), .rst (rst), .pd (pwr_dn),
    .ratio_in (fb_ratio), .div_o (fb_div_o)
  );

  sdiv_core #(.RW(POST_RW)) u_post (
    .clk (clk_vco), .rst (rst), .pd (pwr_dn),
    .ratio_in (post_ratio), .div_o (out_clk_o)
  );
endmodule

// File: tb/sim_synth_div_bank.sv
`timescale 1ps/1ps
module sim_synth_div_bank;
  localparam int VCO_HALF = 2500;   // 200 MHz
  localparam int REF_HALF = 5000;   // 100 MHz
  localparam int TV = 2 * VCO_HALF;
  localparam int TR = 2 * REF_HALF;

  logic clk_ref = 1'b0, clk_vco = 1'b0;
  logic rst = 1'b1, pwr_dn = 1'b0, tst_sel = 1'b0;
  logic [15:0] cfg_word = 16'h0000, tst_word = 16'h0000;
  logic ref_div_o, fb_div_o, out_clk_o;

  always #VCO_HALF clk_vco = ~clk_vco;
  always #REF_HALF clk_ref = ~clk_ref;

  synth_div_bank u0 (
    .clk_ref (clk_ref), .clk_vco (clk_vco), .rst (rst), .pwr_dn (pwr_dn),
    .cfg_word (cfg_word), .tst_sel (tst_sel), .tst_word (tst_word),
    .ref_div_o (ref_div_o), .fb_div_o (fb_div_o), .out_clk_o (out_clk_o)
  );

  typedef struct { int per; int hi; string tag; } exp_t;
  exp_t exp_q[$];
  int n_tests = 0, n_fail = 0, n_done = 0;
  int mon_sel = 0;
  logic mon_sig;
  assign mon_sig = (mon_sel == 0) ? ref_div_o : (mon_sel == 1) ? fb_div_o : out_clk_o;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: measures each period of the selected output and compares with the queue head
  initial begin
    int t_r, t_f, t_r2;
    exp_t e;
    forever begin
      wait (exp_q.size() > 0);
      @(posedge mon_sig); t_r = $time;
      while (exp_q.size() > 0) begin
        @(negedge mon_sig); t_f = $time;
        @(posedge mon_sig); t_r2 = $time;
        e = exp_q.pop_front();
        chk((t_r2 - t_r) == e.per, e.tag, "period", t_r2 - t_r, e.per);
        chk((t_f - t_r) == e.hi, e.tag, "high", t_f - t_r, e.hi);
        t_r = t_r2;
        n_done++;
      end
    end
  end

  task automatic push(input int n, input int per, input int hi, input string tag);
    exp_t e;
    e.per = per; e.hi = hi; e.tag = tag;
    for (int i = 0; i < n; i++) exp_q.push_back(e);
  endtask

  task automatic meas(input int sel, input int n, input int per, input int hi, input string tag);
    int target;
    mon_sel = sel;
    repeat (2) @(posedge mon_sig);
    target = n_done + n;
    push(n, per, hi, tag);
    wait (n_done >= target);
  endtask

  // R4: word = {M[7:0], P[5:0], S[1:0]}
  task automatic set_cfg(input int m, input int p, input int s);
    @(negedge clk_vco); #1000;
    cfg_word = {8'(m), 6'(p), 2'(s)};
  endtask

  initial begin
    #200_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int target;
    cfg_word = {8'd2, 6'd1, 2'd1};
    tst_word = {8'd12, 6'd3, 2'd3};
    repeat (6) @(posedge clk_ref);
    #1000;
    // R10: outputs low while reset is held
    chk(ref_div_o == 1'b0, "R10", "ref_div_o in reset", ref_div_o, 0);
    chk(fb_div_o == 1'b0, "R10", "fb_div_o in reset", fb_div_o, 0);
    chk(out_clk_o == 1'b0, "R10", "out_clk_o in reset", out_clk_o, 0);
    @(negedge clk_vco); #1000; rst = 1'b0;

    meas(0, 3, 3*TR, 15000, "R1 R5 P=1");
    set_cfg(2, 0, 1);
    meas(0, 3, 2*TR, TR, "R1 R6 P=0");
    set_cfg(2, 63, 1);
    meas(0, 2, 65*TR, 325000, "R1 R5 P=63");

    set_cfg(2, 1, 1);
    meas(1, 3, 10*TV, 5*TV, "R2 R6 M=2");
    set_cfg(1, 1, 1);
    meas(1, 3, 9*TV, 22500, "R2 R5 M=1");
    set_cfg(0, 1, 1);
    meas(1, 3, 8*TV, 4*TV, "R2 M=0");
    set_cfg(255, 1, 1);
    meas(1, 2, 263*TV, 657500, "R2 R5 M=255");

    set_cfg(2, 1, 0);
    meas(2, 4, TV, VCO_HALF, "R3 R11 S=0");
    set_cfg(2, 1, 1);
    meas(2, 3, 2*TV, TV, "R3 S=1");
    set_cfg(2, 1, 2);
    meas(2, 3, 4*TV, 2*TV, "R3 S=2");
    set_cfg(2, 1, 3);
    meas(2, 3, 8*TV, 4*TV, "R3 S=3");

    // R4: all three fields at once
    set_cfg(3, 4, 2);
    meas(1, 2, 11*TV, 27500, "R4 fb");
    meas(0, 2, 6*TR, 3*TR, "R4 ref");
    meas(2, 2, 4*TV, 2*TV, "R4 out");

    // R9: test word replaces the configuration word
    @(negedge clk_vco); #1000; tst_sel = 1'b1;
    meas(1, 2, 20*TV, 10*TV, "R9 fb");
    meas(0, 2, 5*TR, 25000, "R9 ref");
    meas(2, 2, 8*TV, 4*TV, "R9 out");
    @(negedge clk_vco); #1000; tst_sel = 1'b0;
    meas(0, 2, 6*TR, 3*TR, "R9 back");

    // R7: change the code partway through a period of ratio 7
    set_cfg(3, 5, 2);
    mon_sel = 0;
    repeat (2) @(posedge mon_sig);
    target = n_done + 4;
    push(1, 7*TR, 35000, "R7 old");
    push(3, 3*TR, 15000, "R7 new");
    @(posedge mon_sig);
    repeat (2) @(negedge clk_ref);
    cfg_word = {8'd3, 6'd1, 2'd2};
    wait (n_done >= target);

    // R8: power-down silences every output
    @(negedge clk_vco); #1000; pwr_dn = 1'b1;
    repeat (4) @(posedge clk_ref);
    for (int i = 0; i < 8; i++) begin
      #3100;
      chk(ref_div_o == 1'b0, "R8", "ref_div_o in power-down", ref_div_o, 0);
      chk(fb_div_o == 1'b0, "R8", "fb_div_o in power-down", fb_div_o, 0);
      chk(out_clk_o == 1'b0, "R8", "out_clk_o in power-down", out_clk_o, 0);
    end
    @(negedge clk_vco); #1000; pwr_dn = 1'b0;
    meas(0, 2, 3*TR, 15000, "R8 restart ref");
    meas(1, 2, 11*TV, 27500, "R8 restart fb");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule